// File: doc/BRIEF.md
# Bus-Mapped Down-Counting Interval Timer

A 32-bit interval timer placed behind a simple memory-mapped bus with 16-bit data. Software programs a 32-bit period as two 16-bit halves. It then writes a control word that enables the interrupt, picks one-shot or continuous operation, and issues start or stop commands. The counter decrements once per clock from the period toward zero. One full interval spans period + 1 clocks. Reaching zero sets a sticky timeout flag, which drives the interrupt line when the interrupt is enabled.

A write to the snapshot-low address freezes the live 32-bit count. Software then reads the frozen value back as two halves, so the two halves are consistent even though the counter keeps running. Register reads are combinational from the address and have no side effects. All actions happen on a write strobe (`sel_i` and `we_i` high) at the rising clock edge.

Top module: `ival_timer`

## Requirements
- R1: After reset the counter is stopped and holds all ones, the period reads 0xFFFF in both halves, control and status read 0, the snapshot reads 0 and `irq_o` is low.
- R2: A write to either period half (word 2 = low, word 3 = high) updates that half, stops the counter and loads the full new 32-bit period into it on the same edge; both halves read back.
- R3: While running, the counter decrements by one per clock. In the clock where it sits at zero, the timeout flag (status bit 0) is set on the next edge, so the flag rises period + 1 edges after the start edge.
- R4: With continuous mode off (control bit 1 = 0), a timeout reloads the period and stops the counter; status bit 1 (running) reads 0 afterwards.
- R5: With continuous mode on, a timeout reloads the period and the counter keeps running, giving a timeout every period + 1 clocks.
- R6: Control bit 2 (start) sets the counter running and control bit 3 (stop) halts it without a decrement on that edge. If both are written together, stop wins. Neither bit is stored; both read as 0.
- R7: Any write to the snapshot-low address (word 4) copies the live count into the snapshot, which reads back as words 4 (low) and 5 (high) and holds until the next such write. Writes to word 5 capture nothing.
- R8: Any write to the status register (word 0) clears the timeout flag, whatever the data. A timeout on the same edge wins and leaves the flag set.
- R9: `irq_o` is high exactly when the timeout flag and the interrupt-enable bit (control bit 0) are both set.
- R10: The word index is `addr_i[4:2]` (byte offsets 0, 4, 8, 12, 16, 20). `rdata_o` reflects the addressed register in the same cycle. Control reads back {continuous, enable} in bits 1:0, and status reads back {running, timeout} in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus select |
| we_i | input | 1 | Write enable (with sel_i) |
| addr_i | input | 5 | Byte address; bits 4:2 select the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the addressed register |
| irq_o | output | 1 | Timeout interrupt |

## Verification
The bench counts edges from the start write and checks that the flag is still low one edge before period + 1. A design with an off-by-one interval would flag too early or too late. It clears status on the very edge of a continuous-mode timeout, where a clear-wins design would silently lose an event. It writes start and stop together and checks the counter stays halted, and it checks that stop suppresses the decrement on its own edge, which a design with a one-count drift would get wrong. It also checks that the snapshot stays frozen while the counter runs, and that writes to the snapshot-high word do not recapture, which a design with a live read path or a loose address decode would miss.

// File: rtl/ival_timer_pkg.sv
package ival_timer_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 5;

  // word indices (byte offset / 4)
  localparam int unsigned REG_STATUS  = 0;
  localparam int unsigned REG_CTRL    = 1;
  localparam int unsigned REG_PER_LO  = 2;
  localparam int unsigned REG_SNAP_LO = 4;

  // control bits
  localparam int unsigned CTRL_IE   = 0;
  localparam int unsigned CTRL_CONT = 1;
  localparam int unsigned CTRL_GO   = 2;
  localparam int unsigned CTRL_HALT = 3;

  // status bits
  localparam int unsigned STAT_TO  = 0;
  localparam int unsigned STAT_RUN = 1;
endpackage

// File: rtl/ival_timer_regs.sv
module ival_timer_regs
  import ival_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = ival_timer_pkg::CNT_W,
  parameter int unsigned DATA_W = ival_timer_pkg::DATA_W,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              st_wr_o,
  output logic              snap_wr_o,
  output logic              go_o,
  output logic              halt_o,
  output logic              per_wr_o,
  output logic [CNT_W-1:0]  per_new_o,
  output logic [CNT_W-1:0]  period_o,
  output logic              ie_o,
  output logic              cont_o
);
  localparam int unsigned HALVES = CNT_W / DATA_W;

  logic             ctrl_wr;
  logic [HALVES-1:0] half_wr;
  logic [CNT_W-1:0] period_q;
  logic             ie_q, cont_q;

  assign st_wr_o   = wr_i && (idx_i == IDX_W'(REG_STATUS));
  assign ctrl_wr   = wr_i && (idx_i == IDX_W'(REG_CTRL));
  assign snap_wr_o = wr_i && (idx_i == IDX_W'(REG_SNAP_LO));
  assign go_o      = ctrl_wr && wdata_i[CTRL_GO];
  assign halt_o    = ctrl_wr && wdata_i[CTRL_HALT];

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half_wr[h] = wr_i && (idx_i == IDX_W'(REG_PER_LO + h));
  end

  always_comb begin
    per_new_o = period_q;
    for (int h = 0; h < HALVES; h++) begin
      if (half_wr[h]) per_new_o[h*DATA_W +: DATA_W] = wdata_i;
    end
  end

  assign per_wr_o = |half_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '1;
      ie_q     <= 1'b0;
      cont_q   <= 1'b0;
    end else begin
      if (per_wr_o) period_q <= per_new_o;
      if (ctrl_wr) begin
        ie_q   <= wdata_i[CTRL_IE];
        cont_q <= wdata_i[CTRL_CONT];
      end
    end
  end

  assign period_o = period_q;
  assign ie_o     = ie_q;
  assign cont_o   = cont_q;
endmodule

// File: rtl/ival_timer_count.sv
module ival_timer_count #(
  parameter int unsigned CNT_W = ival_timer_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             halt_i,
  input  logic             per_wr_i,
  input  logic [CNT_W-1:0] per_new_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             cont_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             tmo_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             tick;

  // stop and period load take the edge; no decrement then
  assign tick  = run_q && !halt_i && !per_wr_i;
  assign tmo_o = tick && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      run_q <= 1'b0;
    end else if (per_wr_i) begin
      cnt_q <= per_new_i;
      run_q <= 1'b0;
    end else if (halt_i) begin
      run_q <= 1'b0;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_q <= period_i;
        run_q <= cont_i || go_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (go_i) begin
      run_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/ival_timer_latch.sv
module ival_timer_latch #(
  parameter int unsigned CNT_W = ival_timer_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tmo_i,
  input  logic             st_wr_i,
  input  logic             snap_wr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             to_o,
  output logic [CNT_W-1:0] snap_o
);
  logic             to_q;
  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q   <= 1'b0;
      snap_q <= '0;
    end else begin
      // a fresh timeout beats a clear on the same edge
      if (tmo_i)        to_q <= 1'b1;
      else if (st_wr_i) to_q <= 1'b0;
      if (snap_wr_i) snap_q <= cnt_i;
    end
  end

  assign to_o   = to_q;
  assign snap_o = snap_q;
endmodule

// File: rtl/ival_timer.sv
module ival_timer
  import ival_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = ival_timer_pkg::CNT_W,
  parameter int unsigned DATA_W = ival_timer_pkg::DATA_W,
  parameter int unsigned ADDR_W = ival_timer_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned HALVES = CNT_W / DATA_W;

  logic [IDX_W-1:0] idx;
  logic             st_wr, snap_wr, go, halt, per_wr, tmo;
  logic [CNT_W-1:0] per_new, period_q, cnt_q, snap_q;
  logic             ie_q, cont_q, run_q, to_q;
  logic             unused_addr;

  assign idx         = addr_i[ADDR_W-1:2];
  assign unused_addr = ^addr_i[1:0];

  ival_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (sel_i && we_i),
    .idx_i     (idx),
    .wdata_i   (wdata_i),
    .st_wr_o   (st_wr),
    .snap_wr_o (snap_wr),
    .go_o      (go),
    .halt_o    (halt),
    .per_wr_o  (per_wr),
    .per_new_o (per_new),
    .period_o  (period_q),
    .ie_o      (ie_q),
    .cont_o    (cont_q)
  );

  ival_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .halt_i    (halt),
    .per_wr_i  (per_wr),
    .per_new_i (per_new),
    .period_i  (period_q),
    .cont_i    (cont_q),
    .cnt_o     (cnt_q),
    .run_o     (run_q),
    .tmo_o     (tmo)
  );

  ival_timer_latch #(.CNT_W(CNT_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tmo_i     (tmo),
    .st_wr_i   (st_wr),
    .snap_wr_i (snap_wr),
    .cnt_i     (cnt_q),
    .to_o      (to_q),
    .snap_o    (snap_q)
  );

  always_comb begin
    rdata_o = '0;
    if (idx == IDX_W'(REG_STATUS)) begin
      rdata_o[STAT_TO]  = to_q;
      rdata_o[STAT_RUN] = run_q;
    end
    if (idx == IDX_W'(REG_CTRL)) begin
      rdata_o[CTRL_IE]   = ie_q;
      rdata_o[CTRL_CONT] = cont_q;
    end
    for (int h = 0; h < HALVES; h++) begin
      if (idx == IDX_W'(REG_PER_LO + h))  rdata_o = period_q[h*DATA_W +: DATA_W];
      if (idx == IDX_W'(REG_SNAP_LO + h)) rdata_o = snap_q[h*DATA_W +: DATA_W];
    end
  end

  assign irq_o = to_q && ie_q;
endmodule

// File: rtl/ival_timer_chk.sv
module ival_timer_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             we_i,
  input logic [IDX_W-1:0] idx_i,
  input logic             go_bit_i,
  input logic             halt_bit_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] period_i,
  input logic [CNT_W-1:0] snap_i,
  input logic             run_i,
  input logic             to_i,
  input logic             ie_i,
  input logic             cont_i,
  input logic             irq_i
);
  logic wr, st_w, ctrl_w, per_w, snap_w, halt_w;
  assign wr     = sel_i && we_i;
  assign st_w   = wr && (idx_i == IDX_W'(0));
  assign ctrl_w = wr && (idx_i == IDX_W'(1));
  assign per_w  = wr && ((idx_i == IDX_W'(2)) || (idx_i == IDX_W'(3)));
  assign snap_w = wr && (idx_i == IDX_W'(4));
  assign halt_w = ctrl_w && halt_bit_i;

  a_r2_period_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_w |=> (!run_i && cnt_i == period_i));

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i != '0 && !halt_w && !per_w) |=> (cnt_i == $past(cnt_i) - 1'b1));

  a_r4_oneshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == '0 && !cont_i && !ctrl_w && !per_w) |=> (!run_i && to_i && cnt_i == period_i));

  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == '0 && cont_i && !ctrl_w && !per_w) |=> (run_i && to_i && cnt_i == period_i));

  a_r6_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_w |=> !run_i);

  a_r6_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_w && go_bit_i && !halt_bit_i) |=> run_i);

  a_r7_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_w |=> (snap_i == $past(cnt_i)));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_w |=> $stable(snap_i));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_w && !(run_i && cnt_i == '0 && !halt_w && !per_w)) |=> !to_i);

  a_r9_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (to_i && ie_i));
endmodule

bind ival_timer ival_timer_chk #(.CNT_W(CNT_W), .IDX_W(ADDR_W - 2)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .we_i       (we_i),
  .idx_i      (addr_i[ADDR_W-1:2]),
  .go_bit_i   (wdata_i[2]),
  .halt_bit_i (wdata_i[3]),
  .cnt_i      (cnt_q),
  .period_i   (period_q),
  .snap_i     (snap_q),
  .run_i      (run_q),
  .to_i       (to_q),
  .ie_i       (ie_q),
  .cont_i     (cont_q),
  .irq_i      (irq_o)
);

// File: tb/ival_timer_bench.sv
module ival_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  localparam logic [4:0] A_ST = 5'd0, A_CTL = 5'd4, A_PLO = 5'd8, A_PHI = 5'd12,
                         A_SLO = 5'd16, A_SHI = 5'd20;

  always #4 clk = ~clk;

  ival_timer u_ival_timer (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // starts and ends just after a falling edge
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_reg(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic chk_snap(input string req, input logic [31:0] exp);
    logic [15:0] hi, lo;
    wr(A_SLO, 16'h0);
    rd(A_SHI, hi);
    rd(A_SLO, lo);
    check(req, {hi, lo}, exp);
  endtask

  task automatic t_reset;
    chk_reg("R1 status", A_ST, 16'h0000);
    chk_reg("R1 control", A_CTL, 16'h0000);
    chk_reg("R1 period low", A_PLO, 16'hFFFF);
    idle(1);
    chk_reg("R1 period high", A_PHI, 16'hFFFF);
    chk_reg("R1 snapshot low", A_SLO, 16'h0000);
    check("R1 irq", {31'h0, irq}, 32'h0);
    idle(1);
    chk_snap("R1 R7 count all ones", 32'hFFFF_FFFF);
    idle(1);
  endtask

  task automatic t_oneshot;
    wr(A_PLO, 16'd5);
    wr(A_PHI, 16'd0);
    chk_reg("R2 R10 period low readback", A_PLO, 16'd5);
    chk_reg("R2 R10 period high readback", A_PHI, 16'd0);
    wr(A_CTL, 16'h0005);
    idle(5);
    chk_reg("R3 no flag one edge early", A_ST, 16'h0002);
    check("R9 irq low before timeout", {31'h0, irq}, 32'h0);
    idle(1);
    chk_reg("R3 R4 flag set, stopped", A_ST, 16'h0001);
    check("R9 irq on timeout", {31'h0, irq}, 32'h1);
    chk_snap("R4 reloaded period", 32'd5);
    wr(A_ST, 16'h1234);
    chk_reg("R8 status clear", A_ST, 16'h0000);
    check("R8 irq cleared", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_irq_gate;
    wr(A_CTL, 16'h0004);
    idle(6);
    chk_reg("R9 flag set with irq disabled", A_ST, 16'h0001);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    wr(A_CTL, 16'h0001);
    check("R9 irq on enable", {31'h0, irq}, 32'h1);
    chk_reg("R10 control readback", A_CTL, 16'h0001);
    wr(A_ST, 16'h0000);
    check("R9 irq after clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_cont;
    wr(A_PLO, 16'd3);
    wr(A_CTL, 16'h0007);
    idle(3);
    chk_reg("R5 running before timeout", A_ST, 16'h0002);
    idle(1);
    chk_reg("R5 timeout, still running", A_ST, 16'h0003);
    check("R5 R9 irq", {31'h0, irq}, 32'h1);
    chk_reg("R10 control cont readback", A_CTL, 16'h0003);
    wr(A_ST, 16'h0000);
    chk_reg("R8 cleared while running", A_ST, 16'h0002);
    idle(2);
    chk_reg("R5 second interval pending", A_ST, 16'h0002);
    wr(A_ST, 16'h0000);
    chk_reg("R8 R5 timeout beats clear", A_ST, 16'h0003);
    wr(A_CTL, 16'h0008);
    chk_reg("R6 stop halts", A_ST, 16'h0001);
    wr(A_ST, 16'h0000);
    chk_reg("R8 final clear", A_ST, 16'h0000);
  endtask

  task automatic t_stopgo;
    wr(A_PLO, 16'h0000);
    wr(A_PHI, 16'h0001);
    chk_snap("R2 full period loaded", 32'h0001_0000);
    wr(A_CTL, 16'h0004);
    idle(10);
    wr(A_CTL, 16'h0008);
    chk_snap("R6 stop after ten decrements", 32'h0000_FFF6);
    wr(A_CTL, 16'h0004);
    idle(3);
    wr(A_CTL, 16'h0008);
    chk_snap("R6 resume from held count", 32'h0000_FFF3);
    wr(A_CTL, 16'h000C);
    idle(5);
    chk_reg("R6 stop wins over start", A_ST, 16'h0000);
    chk_snap("R6 count unchanged", 32'h0000_FFF3);
  endtask

  task automatic t_snap;
    logic [15:0] hi, lo;
    wr(A_CTL, 16'h0004);
    idle(2);
    wr(A_SLO, 16'hABCD);
    idle(4);
    rd(A_SHI, hi);
    rd(A_SLO, lo);
    check("R7 snapshot frozen", {hi, lo}, 32'h0000_FFF1);
    wr(A_SHI, 16'h0000);
    chk_reg("R7 high write no capture", A_SLO, 16'hFFF1);
    chk_reg("R6 still running", A_ST, 16'h0002);
    wr(A_PLO, 16'h0009);
    chk_reg("R2 period write stops", A_ST, 16'h0000);
    chk_snap("R2 merged period loaded", 32'h0001_0009);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_oneshot();
    t_irq_gate();
    t_cont();
    t_stopgo();
    t_snap();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule